// File: doc/BRIEF.md
# Randomized Instruction Decode Front-End

This block sits between instruction fetch and the native instruction decoder of a small 32-bit RISC core whose program image is stored in an untrusted external memory in a scrambled form. For each fetched word it restores the native instruction before the decoder sees it. It removes two layers. The first is a homophonic opcode substitution, in which several encoded opcode values (or, for register-type words, several opcode/funct pairs) stand for one native operation. The second is a bit permutation of the 26-bit operand field, where the permutation in use depends on which chunk of program memory the word was fetched from.

A small set of opcodes passes through untouched: jump, call, return, the two compare-and-branch forms, sleep, and the two transfers between the I/O interface register and memory. Two encoded opcodes are reserved as tripwires. Fetching one of them raises a one-cycle trap request for the tamper unit, and no instruction is issued. The substitution tables and the permutations are fixed by parameters when the block is elaborated.

Words enter and leave on valid/ready streams. The block takes the place of the decode-stage input register, so it adds no cycle over a native pipeline, and every class of instruction takes the same single register stage. A word is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result held while `out_ready` is low stays unchanged until it is taken. The upstream source may change or withdraw an offered word that has not yet been accepted.

Top module: `rand_decode_front`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` and `trap_req` are 0 and `in_ready` is 1.
- R2: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_insn` holds its value.
- R3: A non-reserved word accepted at a rising edge appears on `out_insn` with `out_valid` high right after that edge, the same for every instruction class. When nothing is accepted and `out_ready` is 1, `out_valid` falls.
- R4: Words whose opcode (bits 31..26) is 0x02, 0x03, 0x04, 0x05, 0x06, 0x07, 0x30 or 0x38 are passed on bit for bit, with no substitution and no permutation.
- R5: Accepting a word whose opcode is 0x3E or 0x3F sets `trap_req` to 1 for the following cycle and leaves `out_valid` at 0. `trap_req` is 0 in every cycle that does not follow such an acceptance.
- R6: For permuted words, native operand bit j (j = 0..25) equals encoded operand bit ((j·s + o) mod 26). With p as the permutation index, s is taken from the list 1, 3, 5, 7, 9, 11, 15, 17 at position p, and o = (7p + 5) mod 26.
- R7: The permutation index is p = (word address >> 4) mod 4, where word address = pc >> 2, giving 4 permutations over chunks of 16 words.
- R8: Any opcode that is not a bypass, reserved or register-group opcode is a homophone. The native opcode is the entry at index (((op·37 + 11) mod 64) mod 8) of the list 0x08, 0x0A, 0x0C, 0x0D, 0x0E, 0x0F, 0x23, 0x2B. The native operand comes from R6.
- R9: Opcodes 0x00 (g = 0) and 0x01 (g = 1) form the register group. The output opcode is 0x00 and bits 25..6 come from the de-permuted operand. With f as de-permuted bits 5..0 and k = g·64 + f, the native funct is the entry at index (((k·37 + 11) mod 128) mod 8) of the list 0x20, 0x22, 0x24, 0x25, 0x26, 0x2A, 0x00, 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Fetched word is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 32 | Encoded fetched word |
| in_pc | input | 32 | Byte address the word was fetched from |
| out_valid | output | 1 | Native instruction is held |
| out_ready | input | 1 | Native decoder takes the instruction |
| out_insn | output | 32 | Restored native instruction |
| trap_req | output | 1 | One-cycle request to the tamper unit |

## Verification
The assertions assume that `in_valid`, `in_word` and `out_ready` carry known values after reset. They do not require an offered word to be held until it is accepted, because the block registers only what it accepts. The stimulus changes inputs only at falling edges. It keeps `in_pc` word-aligned and spreads it over many chunks. It mixes bypass, reserved, register-group and random opcodes under randomly stalled and unstalled consumers, so that words held under back-pressure, back-to-back traps and permutation switches between chunks all occur.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int OPND_W = 26;

  typedef enum logic [1:0] {
    CLS_HOMO = 2'd0,
    CLS_REG  = 2'd1,
    CLS_PASS = 2'd2,
    CLS_RESV = 2'd3
  } insn_class_e;

  // affine scramble over a 2**width space; odd multiplier keeps it bijective
  function automatic int unsigned scramble(input int unsigned x, input int unsigned mul,
                                           input int unsigned add, input int unsigned width);
    int unsigned m;
    m = (32'd1 << width) - 32'd1;
    return (x * mul + add) & m;
  endfunction
endpackage

// File: rtl/rdec_classify.sv
module rdec_classify
  import rdec_pkg::*;
#(
  parameter int N_PASS = 8,
  parameter logic [N_PASS*OP_W-1:0] PASS_OPS = '0,
  parameter int N_RESV = 2,
  parameter logic [N_RESV*OP_W-1:0] RESV_OPS = '0,
  parameter int N_RGRP = 2,
  parameter logic [N_RGRP*OP_W-1:0] RGRP_OPS = '0,
  localparam int RSEL_W = (N_RGRP > 1) ? $clog2(N_RGRP) : 1
) (
  input  logic [OP_W-1:0]   enc_op,
  output insn_class_e       cls,
  output logic [RSEL_W-1:0] rsel
);
  logic [N_PASS-1:0] pass_hit;
  logic [N_RESV-1:0] resv_hit;
  logic [N_RGRP-1:0] rgrp_hit;

  for (genvar i = 0; i < N_PASS; i++) begin : g_pass
    assign pass_hit[i] = (enc_op == PASS_OPS[i*OP_W +: OP_W]);
  end
  for (genvar i = 0; i < N_RESV; i++) begin : g_resv
    assign resv_hit[i] = (enc_op == RESV_OPS[i*OP_W +: OP_W]);
  end
  for (genvar i = 0; i < N_RGRP; i++) begin : g_rgrp
    assign rgrp_hit[i] = (enc_op == RGRP_OPS[i*OP_W +: OP_W]);
  end

  always_comb begin
    rsel = '0;
    for (int i = 0; i < N_RGRP; i++) begin
      if (rgrp_hit[i]) rsel = RSEL_W'(i);
    end
  end

  // reserved wins over everything, then bypass, then the register group
  always_comb begin
    if (|resv_hit)      cls = CLS_RESV;
    else if (|pass_hit) cls = CLS_PASS;
    else if (|rgrp_hit) cls = CLS_REG;
    else                cls = CLS_HOMO;
  end
endmodule

// File: rtl/rdec_operand_perm.sv
module rdec_operand_perm
  import rdec_pkg::*;
#(
  parameter int NUM_PERM   = 4,
  parameter int CHUNK_LOG2 = 4,
  parameter int PERM_KEY   = 5,
  localparam int IDX_W = (NUM_PERM > 1) ? $clog2(NUM_PERM) : 1
) (
  input  logic [WORD_W-1:0] pc,
  input  logic [OPND_W-1:0] opnd_enc,
  output logic [OPND_W-1:0] opnd_nat
);
  if (!(NUM_PERM == 1 || NUM_PERM == 2 || NUM_PERM == 4 || NUM_PERM == 8)) begin : g_bad
    $error("NUM_PERM must be 1, 2, 4 or 8");
  end

  logic [IDX_W-1:0]  idx;
  logic [OPND_W-1:0] cand [NUM_PERM];

  // chunk index from the word address
  if (NUM_PERM > 1) begin : g_idx
    assign idx = pc[2 + CHUNK_LOG2 +: IDX_W];
    logic unused_pc;
    assign unused_pc = ^{pc[WORD_W-1:2+CHUNK_LOG2+IDX_W], pc[1+CHUNK_LOG2:0]};
  end else begin : g_idx1
    assign idx = '0;
    logic unused_pc;
    assign unused_pc = ^pc;
  end

  for (genvar p = 0; p < NUM_PERM; p++) begin : g_perm
    localparam int BASE   = 2 * p + 1;
    localparam int STRIDE = (BASE >= 13) ? BASE + 2 : BASE;
    localparam int OFFSET = (7 * p + PERM_KEY) % OPND_W;
    for (genvar j = 0; j < OPND_W; j++) begin : g_bit
      localparam int SRC = (j * STRIDE + OFFSET) % OPND_W;
      assign cand[p][j] = opnd_enc[SRC];
    end
  end

  always_comb begin
    opnd_nat = cand[0];
    for (int p = 0; p < NUM_PERM; p++) begin
      if (idx == IDX_W'(p)) opnd_nat = cand[p];
    end
  end
endmodule

// File: rtl/rdec_homophone.sv
module rdec_homophone
  import rdec_pkg::*;
#(
  parameter int N_NAT_OP = 8,
  parameter logic [N_NAT_OP*OP_W-1:0] NAT_OPS = '0,
  parameter int N_NAT_FN = 8,
  parameter logic [N_NAT_FN*FN_W-1:0] NAT_FNS = '0,
  parameter int MIX_MUL = 37,
  parameter int MIX_ADD = 11,
  parameter int RSEL_W  = 1,
  localparam int KEY_W  = RSEL_W + FN_W
) (
  input  logic [OP_W-1:0]   enc_op,
  input  logic [FN_W-1:0]   enc_fn,
  input  logic [RSEL_W-1:0] rsel,
  output logic [OP_W-1:0]   nat_op,
  output logic [FN_W-1:0]   nat_fn
);
  int unsigned op_slot;
  int unsigned fn_slot;
  logic [KEY_W-1:0] key;

  assign key = {rsel, enc_fn};

  always_comb begin
    op_slot = scramble(int'(enc_op), MIX_MUL, MIX_ADD, OP_W) % N_NAT_OP;
    nat_op  = NAT_OPS[op_slot*OP_W +: OP_W];
  end

  always_comb begin
    fn_slot = scramble(int'(key), MIX_MUL, MIX_ADD, KEY_W) % N_NAT_FN;
    nat_fn  = NAT_FNS[fn_slot*FN_W +: FN_W];
  end
endmodule

// File: rtl/rand_decode_front.sv
module rand_decode_front
  import rdec_pkg::*;
#(
  parameter int NUM_PERM   = 4,
  parameter int CHUNK_LOG2 = 4,
  parameter int PERM_KEY   = 5,
  parameter int MIX_MUL    = 37,
  parameter int MIX_ADD    = 11,
  parameter int N_PASS     = 8,
  parameter logic [N_PASS*OP_W-1:0] PASS_OPS =
    {6'h38, 6'h30, 6'h07, 6'h06, 6'h05, 6'h04, 6'h03, 6'h02},
  parameter int N_RESV     = 2,
  parameter logic [N_RESV*OP_W-1:0] RESV_OPS = {6'h3F, 6'h3E},
  parameter int N_RGRP     = 2,
  parameter logic [N_RGRP*OP_W-1:0] RGRP_OPS = {6'h01, 6'h00},
  parameter logic [OP_W-1:0] REG_NAT_OP = 6'h00,
  parameter int N_NAT_OP   = 8,
  parameter logic [N_NAT_OP*OP_W-1:0] NAT_OPS =
    {6'h2B, 6'h23, 6'h0F, 6'h0E, 6'h0D, 6'h0C, 6'h0A, 6'h08},
  parameter int N_NAT_FN   = 8,
  parameter logic [N_NAT_FN*FN_W-1:0] NAT_FNS =
    {6'h02, 6'h00, 6'h2A, 6'h26, 6'h25, 6'h24, 6'h22, 6'h20}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [WORD_W-1:0] in_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_insn,
  output logic              trap_req
);
  localparam int RSEL_W = (N_RGRP > 1) ? $clog2(N_RGRP) : 1;

  insn_class_e        cls;
  logic [RSEL_W-1:0]  rsel;
  logic [OPND_W-1:0]  opnd_nat;
  logic [OP_W-1:0]    nat_op;
  logic [FN_W-1:0]    nat_fn;
  logic [WORD_W-1:0]  nat_word;
  logic               accept;

  rdec_classify #(
    .N_PASS(N_PASS), .PASS_OPS(PASS_OPS),
    .N_RESV(N_RESV), .RESV_OPS(RESV_OPS),
    .N_RGRP(N_RGRP), .RGRP_OPS(RGRP_OPS)
  ) u_cls (
    .enc_op (in_word[WORD_W-1 -: OP_W]),
    .cls    (cls),
    .rsel   (rsel)
  );

  rdec_operand_perm #(
    .NUM_PERM(NUM_PERM), .CHUNK_LOG2(CHUNK_LOG2), .PERM_KEY(PERM_KEY)
  ) u_perm (
    .pc       (in_pc),
    .opnd_enc (in_word[OPND_W-1:0]),
    .opnd_nat (opnd_nat)
  );

  rdec_homophone #(
    .N_NAT_OP(N_NAT_OP), .NAT_OPS(NAT_OPS),
    .N_NAT_FN(N_NAT_FN), .NAT_FNS(NAT_FNS),
    .MIX_MUL(MIX_MUL), .MIX_ADD(MIX_ADD), .RSEL_W(RSEL_W)
  ) u_homo (
    .enc_op (in_word[WORD_W-1 -: OP_W]),
    .enc_fn (opnd_nat[FN_W-1:0]),
    .rsel   (rsel),
    .nat_op (nat_op),
    .nat_fn (nat_fn)
  );

  // funct is recovered only after the operand has been de-permuted
  always_comb begin
    unique case (cls)
      CLS_PASS: nat_word = in_word;
      CLS_REG:  nat_word = {REG_NAT_OP, opnd_nat[OPND_W-1:FN_W], nat_fn};
      CLS_HOMO: nat_word = {nat_op, opnd_nat};
      default:  nat_word = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_insn  <= '0;
      trap_req  <= 1'b0;
    end else if (accept) begin
      trap_req  <= (cls == CLS_RESV);
      out_valid <= (cls != CLS_RESV);
      if (cls != CLS_RESV) out_insn <= nat_word;
    end else begin
      trap_req <= 1'b0;
      if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rdec_checker.sv
module rdec_checker
  import rdec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_insn,
  input logic              trap_req,
  input insn_class_e       cls
);
  logic acc;
  assign acc = in_valid && in_ready;

  always_comb begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!out_valid && !trap_req);
    end
  end

  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_insn));

  a_r3_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cls != CLS_RESV |=> out_valid && !trap_req);

  a_r4_bypass_verbatim: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cls == CLS_PASS |=> out_insn == $past(in_word));

  a_r5_trap_on_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cls == CLS_RESV |=> trap_req && !out_valid);

  a_r5_trap_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !trap_req);
endmodule

bind rand_decode_front rdec_checker u_rdec_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_insn  (out_insn),
  .trap_req  (trap_req),
  .cls       (cls)
);

// File: tb/tb_rand_decode_front.sv
module tb_rand_decode_front;
  localparam int CLK_PERIOD = 10;
  localparam int N_CYCLES   = 4000;

  localparam logic [5:0] BYP [8]  = '{6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h30, 6'h38};
  localparam logic [5:0] RSV [2]  = '{6'h3E, 6'h3F};
  localparam logic [5:0] NOPS [8] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h23, 6'h2B};
  localparam logic [5:0] NFNS [8] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A, 6'h00, 6'h02};
  localparam int STRIDES [8]      = '{1, 3, 5, 7, 9, 11, 15, 17};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_ready, out_valid, out_ready, trap_req;
  logic [31:0] in_word, in_pc, out_insn;

  always #(CLK_PERIOD/2) clk = ~clk;

  rand_decode_front dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .trap_req(trap_req)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  bit    m_valid = 1'b0, m_trap = 1'b0;
  logic [31:0] m_insn = '0;
  string m_tag = "";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] unperm(input logic [25:0] e, input logic [31:0] pc);
    logic [25:0] r;
    int p = int'((pc >> 6) % 4);
    int o = (7 * p + 5) % 26;
    for (int j = 0; j < 26; j++) r[j] = e[(j * STRIDES[p] + o) % 26];
    return r;
  endfunction

  // kind: 0 homophone, 1 register group, 2 bypass, 3 reserved
  function automatic int kind_of(input logic [5:0] op);
    for (int i = 0; i < 2; i++) if (op == RSV[i]) return 3;
    for (int i = 0; i < 8; i++) if (op == BYP[i]) return 2;
    if (op == 6'h00 || op == 6'h01) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] native_of(input logic [31:0] w, input logic [31:0] pc);
    logic [25:0] o;
    int k;
    int kd = kind_of(w[31:26]);
    if (kd == 2) return w;
    o = unperm(w[25:0], pc);
    if (kd == 1) begin
      k = (w[26] ? 64 : 0) + int'(o[5:0]);
      return {6'h00, o[25:6], NFNS[((k * 37 + 11) % 128) % 8]};
    end
    return {NOPS[((int'(w[31:26]) * 37 + 11) % 64) % 8], o};
  endfunction

  function automatic logic [31:0] gen_word();
    logic [5:0] op;
    int r = int'($urandom % 8);
    if (r < 2)      op = BYP[$urandom % 8];
    else if (r == 2) op = RSV[$urandom % 2];
    else if (r < 5) op = 6'($urandom % 2);
    else            op = 6'($urandom);
    return {op, 26'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    int kd;
    in_valid = 1'b0; out_ready = 1'b0; in_word = '0; in_pc = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 trap_req in reset", 32'(trap_req), 32'd0);
    chk("R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    for (int cyc = 0; cyc < N_CYCLES; cyc++) begin
      @(negedge clk);
      chk("R2 R3 out_valid", 32'(out_valid), 32'(m_valid));
      if (m_valid) chk(m_tag, out_insn, m_insn);
      chk("R5 trap_req", 32'(trap_req), 32'(m_trap));
      in_valid  = ($urandom % 4) != 0;
      out_ready = (cyc > 3000) ? 1'b1 : (($urandom % 10) < 7);
      in_word   = gen_word();
      in_pc     = {20'($urandom), 10'($urandom), 2'b00};
      #1;
      chk("R2 in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
      acc = in_valid && (!m_valid || out_ready);
      @(posedge clk);
      if (acc) begin
        kd = kind_of(in_word[31:26]);
        if (kd == 3) begin
          m_valid = 1'b0; m_trap = 1'b1;
        end else begin
          m_valid = 1'b1; m_trap = 1'b0;
          m_insn  = native_of(in_word, in_pc);
          m_tag   = (kd == 2) ? "R4 bypass word" :
                    (kd == 1) ? "R9 R6 R7 register-group word" :
                                "R8 R6 R7 homophone word";
        end
      end else begin
        m_trap = 1'b0;
        if (out_ready) m_valid = 1'b0;
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule